// File: doc/BRIEF.md
# Management Bus PHY-Side Register Responder

This block sits on the device side of a two-wire serial management bus. A single controller on the bus drives the management clock and owns the data line by default. The block samples both wires with the fast system clock. It detects each rising edge of the management clock and follows the incoming frame one bit at a time. A frame is accepted only after a long run of idle-high bits. When the frame's device address equals the address strapped on `local_addr`, the block serves a read or a write against an internal bank of 32 sixteen-bit registers.

On a matching read, the block takes over the shared data line partway through the turnaround. It shifts out the selected register and then lets go of the line again. On a matching write, it gathers the sixteen data bits and updates the register once the last bit has arrived. Every frame that ends, whether completed or abandoned, sends the decoder back to hunting for a fresh idle run.

The decoder is one state machine with these states:
- `ST_HUNT` counts consecutive high bits. It leaves for `ST_START` on a low bit seen after a full run.
- `ST_START` expects a high bit. Otherwise it returns to `ST_HUNT`.
- `ST_OPCODE` collects two bits. It moves to `ST_PHYADDR` on a read or write code, and otherwise returns to `ST_HUNT`.
- `ST_PHYADDR` collects five bits and then moves to `ST_REGADDR`.
- `ST_REGADDR` collects five bits, chooses the serving mode (read, write or pass), and moves to `ST_TURN`.
- `ST_TURN` lasts two bits and then moves to `ST_DATA`.
- `ST_DATA` lasts sixteen bits and then goes back to `ST_HUNT`.

Top module: `mdio_responder`

## Requirements
- R1: After reset the data line is released (`mdio_oe` low) and every register reads back as 0x0000.
- R2: A frame is recognised only if at least 32 consecutive high bits, sampled on rising clock edges, come just before its start pattern. A run of 31 high bits does not enable a frame. A run longer than 32 does.
- R3: The start pattern is a low bit followed by a high bit. If a second low bit follows instead, the decoder goes back to hunting and the rest of the frame has no effect.
- R4: Opcode bits `10` (first bit sent first) select a read and `01` select a write. The codes `00` and `11` make the decoder ignore the rest of the frame.
- R5: The 5-bit device address, sent MSB first, is compared with `local_addr`. If they differ, the frame neither drives the line nor changes any register.
- R6: The 5-bit register address, sent MSB first, selects one of 32 independent registers. Register 0 and register 31 are both reachable.
- R7: On a matching read, the first turnaround bit is left undriven and the second is driven low. The 16 data bits follow MSB first, and the line is released right after the last data bit.
- R8: On a matching write, both turnaround bits are skipped. The 16 data bits are taken MSB first, and the register is updated only after the sixteenth bit.
- R9: The block never drives the data line during a write frame, during a frame for another address, or while hunting.
- R10: A frame that starts right after the previous frame, with no new run of 32 high bits between them, is ignored.
- R11: Each change of `mdio_out` or `mdio_oe` happens within a few system clocks after a rising edge of the management clock. This is well inside 300 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the management clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the bus controller (asynchronous) |
| mdio_in | input | 1 | Resolved level of the shared data line (asynchronous) |
| local_addr | input | 5 | Device address this responder answers to |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line; low means released |

## Verification
The bench tries the preamble boundary from both sides: a 31-bit run must not enable a frame, and a 40-bit run must. A decoder that counted one bit short, or that reset its count on a long run, would write the register or fail to answer. It also sends a broken start, both illegal opcodes, a frame for another device address and frames sent back to back with no new preamble. A decoder that missed any of these would change a register or drive the line, and that shows up either in a later readback or in the expected line value checked for each bit. For reads, the bench checks the turnaround bit by bit and checks that the line is let go right after the last data bit. A design that drove one bit too early or held the line one bit too long would collide with the controller. Registers 0 and 31 are used to catch an address decode that is cut short or misordered.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURN,
        ST_DATA
    } frame_state_t;

    typedef enum logic [1:0] {
        MODE_PASS,
        MODE_READ,
        MODE_WRITE
    } serve_mode_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic bit_stb,
    output logic bit_val
);
    logic [STAGES-1:0] mdc_q;
    logic [STAGES-1:0] dat_q;
    logic              mdc_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q    <= '1;
            dat_q    <= '1;
            mdc_last <= 1'b1;
        end else begin
            mdc_q    <= {mdc_q[STAGES-2:0], mdc};
            dat_q    <= {dat_q[STAGES-2:0], mdio_in};
            mdc_last <= mdc_q[STAGES-1];
        end
    end

    assign bit_stb = mdc_q[STAGES-1] & ~mdc_last;
    assign bit_val = dat_q[STAGES-1];

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R8
    commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_addr == wr_addr)) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_resp_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int PRE_W = $clog2(PRE_LEN + 1);
    localparam int FLD_W = $clog2(DATA_W);
    localparam logic [FLD_W-1:0] ADDR_LAST = FLD_W'(ADDR_W - 1);
    localparam logic [FLD_W-1:0] DATA_LAST = FLD_W'(DATA_W - 1);
    localparam logic [PRE_W-1:0] PRE_FULL  = PRE_W'(PRE_LEN);

    frame_state_t      state, state_n;
    serve_mode_t       mode, mode_n;
    logic [PRE_W-1:0]  pre_cnt, pre_n;
    logic [FLD_W-1:0]  fld, fld_n;
    logic [1:0]        op_sr, op_n;
    logic [ADDR_W-1:0] phy_sr, phy_n;
    logic [ADDR_W-1:0] reg_sr, reg_n;
    logic [DATA_W-2:0] dsr, dsr_n;
    logic [DATA_W-1:0] rshift;
    logic              pre_full;

    assign pre_full = (pre_cnt == PRE_FULL);
    assign rd_addr  = reg_sr;

    // next-state and field collection
    always_comb begin
        state_n = state;
        mode_n  = mode;
        pre_n   = pre_cnt;
        fld_n   = fld;
        op_n    = op_sr;
        phy_n   = phy_sr;
        reg_n   = reg_sr;
        dsr_n   = dsr;
        if (bit_stb) begin
            unique case (state)
                ST_HUNT: begin
                    if (bit_val) begin
                        if (!pre_full) pre_n = pre_cnt + 1'b1;
                    end else begin
                        pre_n = '0;
                        if (pre_full) state_n = ST_START;
                    end
                end
                ST_START: begin
                    fld_n   = '0;
                    state_n = bit_val ? ST_OPCODE : ST_HUNT;
                end
                ST_OPCODE: begin
                    op_n = {op_sr[0], bit_val};
                    if (fld == '0) begin
                        fld_n = fld + 1'b1;
                    end else begin
                        fld_n   = '0;
                        state_n = (op_n == OPC_READ || op_n == OPC_WRITE) ? ST_PHYADDR : ST_HUNT;
                    end
                end
                ST_PHYADDR: begin
                    phy_n = {phy_sr[ADDR_W-2:0], bit_val};
                    if (fld == ADDR_LAST) begin
                        fld_n   = '0;
                        state_n = ST_REGADDR;
                    end else begin
                        fld_n = fld + 1'b1;
                    end
                end
                ST_REGADDR: begin
                    reg_n = {reg_sr[ADDR_W-2:0], bit_val};
                    if (fld == ADDR_LAST) begin
                        fld_n   = '0;
                        state_n = ST_TURN;
                        if (phy_sr != local_addr) mode_n = MODE_PASS;
                        else if (op_sr == OPC_READ) mode_n = MODE_READ;
                        else mode_n = MODE_WRITE;
                    end else begin
                        fld_n = fld + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (fld == '0) begin
                        fld_n = fld + 1'b1;
                    end else begin
                        fld_n   = '0;
                        state_n = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (mode == MODE_WRITE) dsr_n = {dsr[DATA_W-3:0], bit_val};
                    if (fld == DATA_LAST) begin
                        fld_n   = '0;
                        pre_n   = '0;
                        mode_n  = MODE_PASS;
                        state_n = ST_HUNT;
                    end else begin
                        fld_n = fld + 1'b1;
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            mode    <= MODE_PASS;
            pre_cnt <= '0;
            fld     <= '0;
            op_sr   <= '0;
            phy_sr  <= '0;
            reg_sr  <= '0;
            dsr     <= '0;
        end else begin
            state   <= state_n;
            mode    <= mode_n;
            pre_cnt <= pre_n;
            fld     <= fld_n;
            op_sr   <= op_n;
            phy_sr  <= phy_n;
            reg_sr  <= reg_n;
            dsr     <= dsr_n;
        end
    end

    // outputs: line drive and register commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            rshift   <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bit_stb && state == ST_DATA && mode == MODE_WRITE && fld == DATA_LAST) begin
                wr_en   <= 1'b1;
                wr_addr <= reg_sr;
                wr_data <= {dsr, bit_val};
            end
            if (bit_stb && mode == MODE_READ) begin
                if (state == ST_TURN) begin
                    if (fld == '0) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                    end else begin
                        mdio_out <= rd_data[DATA_W-1];
                        rshift   <= {rd_data[DATA_W-2:0], 1'b0};
                    end
                end else if (state == ST_DATA) begin
                    if (fld == DATA_LAST) begin
                        mdio_oe  <= 1'b0;
                        mdio_out <= 1'b0;
                    end else begin
                        mdio_out <= rshift[DATA_W-1];
                        rshift   <= {rshift[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R9
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (mode == MODE_READ && (state == ST_TURN || state == ST_DATA)));

    // R11
    out_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_oe) || !$stable(mdio_out)) |-> $past(bit_stb));

    // R7
    turnaround_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> (state == ST_TURN && mdio_out == 1'b0));

    // R2
    preamble_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) == ST_HUNT) |-> ($past(pre_cnt) == PRE_FULL));

endmodule

// File: rtl/mdio_responder.sv
module mdio_responder #(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] local_addr,
    output logic              mdio_out,
    output logic              mdio_oe
);
    logic              bit_stb;
    logic              bit_val;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_in),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    mdio_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .local_addr (local_addr),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    mdio_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/mdio_responder_test.sv
module mdio_responder_test;
    localparam int H = 10;
    localparam logic [4:0] ME    = 5'h0A;
    localparam logic [4:0] OTHER = 5'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b1;
    logic mac_en = 1'b1;
    logic mac_val = 1'b1;
    logic mdio_out, mdio_oe;
    logic line;

    int total = 0;
    int bad = 0;

    bit    q_oe[$];
    bit    q_val[$];
    bit    q_cv[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    assign line = mac_en ? mac_val : (mdio_oe ? mdio_out : 1'b1);

    mdio_responder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc        (mdc),
        .mdio_in    (line),
        .local_addr (ME),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    // monitor: each slot's expectation is checked 50 ns after the previous rising edge
    always @(negedge mdc) begin
        if (q_oe.size() != 0) begin
            bit e_oe, e_val, e_cv;
            string t;
            e_oe = q_oe.pop_front();
            e_val = q_val.pop_front();
            e_cv = q_cv.pop_front();
            t = q_tag.pop_front();
            total++;
            if (mdio_oe !== e_oe || (e_cv && mdio_out !== e_val)) begin
                bad++;
                $display("FAIL %s oe/out actual=%b/%b expected=%b/%b", t, mdio_oe, mdio_out, e_oe, e_val);
            end
        end
    end

    task automatic slot(input logic en, input logic v, input bit eoe, input bit ev, input bit cv, input string tag);
        q_oe.push_back(eoe); q_val.push_back(ev); q_cv.push_back(cv); q_tag.push_back(tag);
        @(negedge clk) mdc = 1'b0;
        repeat (H/2) @(negedge clk);
        mac_en = en; mac_val = v;
        repeat (H/2) @(negedge clk);
        mdc = 1'b1;
        repeat (H-1) @(negedge clk);
    endtask

    task automatic preamble(input int n, input string tag);
        for (int i = 0; i < n; i++) slot(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic hdr(input logic [1:0] st, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra, input string tag);
        for (int i = 1; i >= 0; i--) slot(1'b1, st[i], 1'b0, 1'b0, 1'b0, tag);
        for (int i = 1; i >= 0; i--) slot(1'b1, op[i], 1'b0, 1'b0, 1'b0, tag);
        for (int i = 4; i >= 0; i--) slot(1'b1, pa[i], 1'b0, 1'b0, 1'b0, tag);
        for (int i = 4; i >= 0; i--) slot(1'b1, ra[i], 1'b0, 1'b0, 1'b0, tag);
    endtask

    // write tail: controller drives turnaround and data, responder never drives (R9)
    task automatic wr_tail(input logic [15:0] d, input string tag);
        slot(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
        slot(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
        for (int i = 15; i >= 0; i--) slot(1'b1, d[i], 1'b0, 1'b0, 1'b0, tag);
    endtask

    // read tail: R7 turnaround Z then 0, data MSB first
    task automatic rd_tail(input bit drive, input logic [15:0] e, input string tag);
        slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
        slot(1'b0, 1'b1, drive, 1'b0, drive, tag);
        for (int i = 15; i >= 0; i--) slot(1'b0, 1'b1, drive, e[i], drive, tag);
    endtask

    task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d, input string tag);
        preamble(32, tag);
        hdr(2'b01, 2'b01, pa, ra, tag);
        wr_tail(d, tag);
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input bit drive, input logic [15:0] e, input string tag);
        preamble(32, tag);
        hdr(2'b01, 2'b10, pa, ra, tag);
        rd_tail(drive, e, tag);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        total++;
        if (mdio_oe !== 1'b0) begin
            bad++;
            $display("FAIL R1 oe actual=%b expected=0", mdio_oe);
        end
        // R1: registers start at zero
        do_read(ME, 5'd5, 1'b1, 16'h0000, "R1");
        // R8 / R7: write then read back
        do_write(ME, 5'd3, 16'hA5C3, "R8");
        do_read(ME, 5'd3, 1'b1, 16'hA5C3, "R7");
        // R6: ends of the register range
        do_write(ME, 5'd0, 16'h1234, "R6");
        do_write(ME, 5'd31, 16'hFEDC, "R6");
        do_read(ME, 5'd0, 1'b1, 16'h1234, "R6");
        do_read(ME, 5'd31, 1'b1, 16'hFEDC, "R6");
        do_read(ME, 5'd3, 1'b1, 16'hA5C3, "R6");
        // R5: other device address
        do_write(OTHER, 5'd3, 16'h0000, "R5");
        do_read(OTHER, 5'd3, 1'b0, 16'h0000, "R5");
        do_read(ME, 5'd3, 1'b1, 16'hA5C3, "R5");
        // R2: 31 high bits are not enough
        preamble(31, "R2");
        hdr(2'b01, 2'b01, ME, 5'd3, "R2");
        wr_tail(16'h0000, "R2");
        do_read(ME, 5'd3, 1'b1, 16'hA5C3, "R2");
        // R2: longer preamble accepted
        preamble(8, "R2");
        do_write(ME, 5'd7, 16'h0F0F, "R2");
        do_read(ME, 5'd7, 1'b1, 16'h0F0F, "R2");
        // R3: broken start pattern
        preamble(32, "R3");
        hdr(2'b00, 2'b01, ME, 5'd7, "R3");
        wr_tail(16'h0000, "R3");
        do_read(ME, 5'd7, 1'b1, 16'h0F0F, "R3");
        // R4: illegal opcodes 11 and 00
        preamble(32, "R4");
        hdr(2'b01, 2'b11, ME, 5'd7, "R4");
        wr_tail(16'h0000, "R4");
        preamble(32, "R4");
        hdr(2'b01, 2'b00, ME, 5'd7, "R4");
        wr_tail(16'h0000, "R4");
        do_read(ME, 5'd7, 1'b1, 16'h0F0F, "R4");
        // R10: back-to-back write without a new preamble
        do_write(ME, 5'd7, 16'h5555, "R10");
        hdr(2'b01, 2'b01, ME, 5'd7, "R10");
        wr_tail(16'h0000, "R10");
        do_read(ME, 5'd7, 1'b1, 16'h5555, "R10");
        // R10 / R11: back-to-back read must not drive
        hdr(2'b01, 2'b10, ME, 5'd7, "R10");
        rd_tail(1'b0, 16'h0000, "R10");
        do_read(ME, 5'd31, 1'b1, 16'hFEDC, "R11");
        preamble(2, "R9");
        finish_run();
    end

endmodule